// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the target side of a two-wire serial bus. It samples the raw clock and data lines with the system clock and resynchronises them. A glitch filter then rejects any level that does not hold for a set number of samples. START and STOP conditions are found on the cleaned lines. Each condition raises a one-cycle event and sets a sticky status bit, and each clears the status bit of the other condition.

After a START, the first byte is compared with a programmable own address. The compare uses either 7-bit or 10-bit addressing, and the general call address is never accepted. On a write, each received byte is shifted in MSB first and then moved into a single holding buffer that the host reads. On a read, the byte the host last wrote into that buffer is shifted out MSB first. The block acknowledges by pulling SDA low during the ninth clock pulse. The output `sda_pull_low` drives an open-drain pad. While `enable` is low the block holds its state cleared, releases SDA, and ignores the bus.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, and on the cycle after `enable` is sampled low, `sda_pull_low`, `start_flag`, `stop_flag`, `buf_full`, `overflow` and `selected` are all 0. While `enable` is low, bus activity raises no event and gets no acknowledge. Raising `enable` again restores normal operation.
- R2: A level change on SDA or SCL that lasts fewer than FILT_LEN (default 3) consecutive clock samples is ignored. A change that lasts exactly FILT_LEN samples is accepted.
- R3: A START (SDA falling while SCL is high) gives a one-cycle `start_evt`, then `start_flag`=1 and `stop_flag`=0. `start_evt` and `stop_evt` are never high together.
- R4: A STOP (SDA rising while SCL is high) gives a one-cycle `stop_evt`, then `stop_flag`=1, `start_flag`=0 and `selected`=0.
- R5: In 7-bit mode (`ten_bit`=0), the first byte after START carries the address in bits [7:1], MSB first, and the R/W bit in bit 0 (1 = read). The block acknowledges it when bits [7:1] equal `own_addr[6:0]`, and it then sets `selected`.
- R6: When the address does not match, SDA is left released for the acknowledge, and every later byte up to the next START is neither acknowledged nor stored.
- R7: The general call address (first byte 0x00) is never acknowledged, even when `own_addr[6:0]` is 0.
- R8: In 10-bit mode, the first byte must be 11110, then `own_addr[9:8]`, then R/W=0. The second byte must equal `own_addr[7:0]`. Each byte is acknowledged only when it agrees, and a mismatch on either byte deselects the block.
- R9: In 10-bit mode, a first byte of 11110, `own_addr[9:8]`, R/W=1 is acknowledged only after a full 10-bit write match that has not since been ended by a STOP. It then starts a transmit.
- R10: A data byte received while selected, with `buf_full`=0, is acknowledged. It appears on `host_rdata` and sets `buf_full`.
- R11: A data byte that completes while `buf_full`=1 is not acknowledged. It sets `overflow` and leaves `host_rdata` unchanged. A one-cycle `host_rd` clears both `buf_full` and `overflow`.
- R12: On a read, the byte written by `host_wr` is sent MSB first. SDA changes only while SCL is low. The same byte is sent again after each master ACK, and SDA is released after a master NACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block active when 1 |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own slave address (7-bit mode uses [6:0]) |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_pull_low | output | 1 | 1 pulls the open-drain data line low |
| host_wr | input | 1 | Loads `host_wdata` into the holding buffer |
| host_wdata | input | 8 | Byte to transmit on a read transfer |
| host_rd | input | 1 | Marks the buffer read and clears overflow |
| host_rdata | output | 8 | Holding buffer contents |
| buf_full | output | 1 | A received byte is waiting to be read |
| overflow | output | 1 | A byte arrived while the buffer was full |
| start_flag | output | 1 | Last condition seen was START |
| stop_flag | output | 1 | Last condition seen was STOP |
| start_evt | output | 1 | One-cycle START event |
| stop_evt | output | 1 | One-cycle STOP event |
| selected | output | 1 | Block is currently addressed |

## Verification
The bench targets the general call byte with an own address of zero. A design that compares only the address bits would acknowledge that byte. It also tests the 10-bit read header sent without a preceding write match, which a design that tracks no addressed state would wrongly accept. A data byte sent into a full buffer must be NACKed and must not overwrite the buffer; a careless design would corrupt `host_rdata` or acknowledge. An SDA pulse one sample shorter than the filter length, and one exactly as long, check where the filter threshold sits: a filter off by one would miss a START or invent one. During transmit, SDA is sampled early and late in every SCL-high phase, so a design that shifts on the wrong edge shows up as an unstable bit.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 10;
   localparam logic [4:0] TEN_PREFIX = 5'b11110;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR_HI,
      ST_ADDR_LO,
      ST_RECV,
      ST_SEND,
      ST_SLV_ACK,
      ST_MST_ACK
   } i2cs_state_e;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic line_i,
   output logic line_o
);
   localparam int RUN_W = $clog2(FILT_LEN + 1);

   if (SYNC_STAGES < 2 || FILT_LEN < 1) begin : g_bad_cfg
      $fatal(1, "i2cs_glitch_filter: SYNC_STAGES must be >= 2 and FILT_LEN >= 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sample;
   logic                   lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sync_q <= '1;
      else if (clr)    sync_q <= '1;
      else             sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   assign sample = sync_q[SYNC_STAGES-1];

   if (FILT_LEN == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   lvl_q <= 1'b1;
         else if (clr) lvl_q <= 1'b1;
         else          lvl_q <= sample;
      end
   end else begin : g_count
      logic [RUN_W-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= 1'b1;
            run_q <= '0;
         end else if (clr) begin
            lvl_q <= 1'b1;
            run_q <= '0;
         end else if (sample != lvl_q) begin
            if (run_q == RUN_W'(FILT_LEN - 1)) begin
               lvl_q <= sample;
               run_q <= '0;
            end else begin
               run_q <= run_q + RUN_W'(1);
            end
         end else begin
            run_q <= '0;
         end
      end
   end

   assign line_o = lvl_q;
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic scl_f,
   input  logic sda_f,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_prev_q;
   logic sda_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev_q <= 1'b1;
         sda_prev_q <= 1'b1;
      end else if (clr) begin
         scl_prev_q <= 1'b1;
         sda_prev_q <= 1'b1;
      end else begin
         scl_prev_q <= scl_f;
         sda_prev_q <= sda_f;
      end
   end

   assign start_o = scl_prev_q & scl_f & sda_prev_q & ~sda_f;
   assign stop_o  = scl_prev_q & scl_f & ~sda_prev_q & sda_f;
   assign rise_o  = ~scl_prev_q & scl_f;
   assign fall_o  = scl_prev_q & ~scl_f;
endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
   import i2cs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              sda_f,
   input  logic              ten_bit_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              buf_full_i,
   input  logic [BYTE_W-1:0] tx_byte_i,
   output logic              sda_low_o,
   output logic              rx_push_o,
   output logic              ovf_set_o,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              selected_o
);
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam int SEVEN  = 7;

   i2cs_state_e       st_q, nxt_q, next_c;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic              sda_low_q, ten_hit_q, mack_q, sel_q, push_q, ovf_q;
   logic              ack_c, sel_c, ten_hit_c, push_c, ovf_c;
   logic              hit7, hit_hi, hit_lo, rw;
   logic              byte_done;

   assign rw       = sh_q[0];
   assign hit7     = (sh_q[BYTE_W-1:1] == own_addr_i[SEVEN-1:0]) && (sh_q[BYTE_W-1:1] != '0);
   assign hit_hi   = (sh_q[BYTE_W-1:3] == TEN_PREFIX) && (sh_q[2:1] == own_addr_i[ADDR_W-1:ADDR_W-2]);
   assign hit_lo   = (sh_q == own_addr_i[BYTE_W-1:0]);
   assign byte_done = (cnt_q == CNT_W'(BYTE_W));

   always_comb begin
      ack_c     = 1'b0;
      next_c    = ST_IDLE;
      sel_c     = 1'b0;
      ten_hit_c = ten_hit_q;
      push_c    = 1'b0;
      ovf_c     = 1'b0;
      case (st_q)
         ST_ADDR_HI: begin
            if (!ten_bit_i) begin
               ack_c  = hit7;
               sel_c  = hit7;
               next_c = hit7 ? (rw ? ST_SEND : ST_RECV) : ST_IDLE;
            end else if (hit_hi && !rw) begin
               ack_c     = 1'b1;
               ten_hit_c = 1'b0;
               next_c    = ST_ADDR_LO;
            end else if (hit_hi && rw && ten_hit_q) begin
               ack_c  = 1'b1;
               sel_c  = 1'b1;
               next_c = ST_SEND;
            end
         end
         ST_ADDR_LO: begin
            ack_c     = hit_lo;
            sel_c     = hit_lo;
            ten_hit_c = hit_lo;
            next_c    = hit_lo ? ST_RECV : ST_IDLE;
         end
         ST_RECV: begin
            sel_c  = sel_q;
            next_c = ST_RECV;
            if (buf_full_i) begin
               ovf_c = 1'b1;
            end else begin
               ack_c  = 1'b1;
               push_c = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr) begin
         st_q      <= ST_IDLE;
         nxt_q     <= ST_IDLE;
         cnt_q     <= '0;
         sh_q      <= '0;
         sda_low_q <= 1'b0;
         ten_hit_q <= 1'b0;
         mack_q    <= 1'b0;
         sel_q     <= 1'b0;
         push_q    <= 1'b0;
         ovf_q     <= 1'b0;
      end else begin
         push_q <= 1'b0;
         ovf_q  <= 1'b0;
         if (start_i) begin
            st_q      <= ST_ADDR_HI;
            cnt_q     <= '0;
            sh_q      <= '0;
            sda_low_q <= 1'b0;
            sel_q     <= 1'b0;
         end else if (stop_i) begin
            st_q      <= ST_IDLE;
            sda_low_q <= 1'b0;
            sel_q     <= 1'b0;
            ten_hit_q <= 1'b0;
         end else begin
            case (st_q)
               ST_ADDR_HI, ST_ADDR_LO, ST_RECV: begin
                  if (rise_i && !byte_done) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
                     cnt_q <= cnt_q + CNT_W'(1);
                  end else if (fall_i && byte_done) begin
                     sda_low_q <= ack_c;
                     nxt_q     <= next_c;
                     st_q      <= ST_SLV_ACK;
                     sel_q     <= sel_c;
                     ten_hit_q <= ten_hit_c;
                     push_q    <= push_c;
                     ovf_q     <= ovf_c;
                  end
               end
               ST_SLV_ACK: begin
                  if (fall_i) begin
                     cnt_q <= '0;
                     st_q  <= nxt_q;
                     if (nxt_q == ST_SEND) begin
                        sh_q      <= tx_byte_i;
                        sda_low_q <= ~tx_byte_i[BYTE_W-1];
                     end else begin
                        sda_low_q <= 1'b0;
                     end
                  end
               end
               ST_SEND: begin
                  if (rise_i) begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end else if (fall_i) begin
                     if (byte_done) begin
                        sda_low_q <= 1'b0;
                        st_q      <= ST_MST_ACK;
                     end else begin
                        sh_q      <= {sh_q[BYTE_W-2:0], 1'b0};
                        sda_low_q <= ~sh_q[BYTE_W-2];
                     end
                  end
               end
               ST_MST_ACK: begin
                  if (rise_i) begin
                     mack_q <= ~sda_f;
                  end else if (fall_i) begin
                     cnt_q <= '0;
                     if (mack_q) begin
                        sh_q      <= tx_byte_i;
                        sda_low_q <= ~tx_byte_i[BYTE_W-1];
                        st_q      <= ST_SEND;
                     end else begin
                        sda_low_q <= 1'b0;
                        sel_q     <= 1'b0;
                        st_q      <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_low_o  = sda_low_q;
   assign rx_push_o  = push_q;
   assign ovf_set_o  = ovf_q;
   assign rx_byte_o  = sh_q;
   assign selected_o = sel_q;
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
   import i2cs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              ten_bit,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_low,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [BYTE_W-1:0] host_rdata,
   output logic              buf_full,
   output logic              overflow,
   output logic              start_flag,
   output logic              stop_flag,
   output logic              start_evt,
   output logic              stop_evt,
   output logic              selected
);
   localparam int N_LINES = 2;

   logic                clr;
   logic [N_LINES-1:0]  raw_lines, filt_lines;
   logic                scl_f, sda_f;
   logic                start_det, stop_det, scl_rise, scl_fall;
   logic                eng_low, rx_push, ovf_set;
   logic [BYTE_W-1:0]   rx_byte;
   logic [BYTE_W-1:0]   hold_q;
   logic                full_q, ovf_q, sflag_q, pflag_q;

   assign clr       = ~enable;
   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_filt
      i2cs_glitch_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN)
      ) filt_i (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .line_i(raw_lines[g]),
         .line_o(filt_lines[g])
      );
   end

   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   i2cs_bus_events events_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .scl_f  (scl_f),
      .sda_f  (sda_f),
      .start_o(start_det),
      .stop_o (stop_det),
      .rise_o (scl_rise),
      .fall_o (scl_fall)
   );

   i2cs_byte_engine engine_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .start_i   (start_det),
      .stop_i    (stop_det),
      .rise_i    (scl_rise),
      .fall_i    (scl_fall),
      .sda_f     (sda_f),
      .ten_bit_i (ten_bit),
      .own_addr_i(own_addr),
      .buf_full_i(full_q),
      .tx_byte_i (hold_q),
      .sda_low_o (eng_low),
      .rx_push_o (rx_push),
      .ovf_set_o (ovf_set),
      .rx_byte_o (rx_byte),
      .selected_o(selected)
   );

   assign start_evt = start_det & enable;
   assign stop_evt  = stop_det & enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         full_q  <= 1'b0;
         ovf_q   <= 1'b0;
         sflag_q <= 1'b0;
         pflag_q <= 1'b0;
      end else if (clr) begin
         full_q  <= 1'b0;
         ovf_q   <= 1'b0;
         sflag_q <= 1'b0;
         pflag_q <= 1'b0;
      end else begin
         if (rx_push)      hold_q <= rx_byte;
         else if (host_wr) hold_q <= host_wdata;

         if (rx_push)      full_q <= 1'b1;
         else if (host_rd) full_q <= 1'b0;

         if (ovf_set)      ovf_q <= 1'b1;
         else if (host_rd) ovf_q <= 1'b0;

         if (start_det) begin
            sflag_q <= 1'b1;
            pflag_q <= 1'b0;
         end else if (stop_det) begin
            sflag_q <= 1'b0;
            pflag_q <= 1'b1;
         end
      end
   end

   assign sda_pull_low = eng_low & enable;
   assign host_rdata   = hold_q;
   assign buf_full     = full_q;
   assign overflow     = ovf_q;
   assign start_flag   = sflag_q;
   assign stop_flag    = pflag_q;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl_f,
   input logic sda_pull_low,
   input logic start_evt,
   input logic stop_evt,
   input logic start_flag,
   input logic stop_flag,
   input logic buf_full,
   input logic overflow,
   input logic selected
);
   assert_off_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!sda_pull_low && !start_flag && !stop_flag && !buf_full && !overflow && !selected));

   assert_start_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (start_flag && !stop_flag));

   assert_events_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_evt && stop_evt));

   assert_stop_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (stop_flag && !start_flag && !selected));

   assert_sda_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(enable) && (sda_pull_low != $past(sda_pull_low))) |-> !$past(scl_f));

   assert_overflow_needs_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> buf_full);
endmodule

bind i2c_addr_slave i2cs_checker chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .scl_f       (scl_f),
   .sda_pull_low(sda_pull_low),
   .start_evt   (start_evt),
   .stop_evt    (stop_evt),
   .start_flag  (start_flag),
   .stop_flag   (stop_flag),
   .buf_full    (buf_full),
   .overflow    (overflow),
   .selected    (selected)
);

// File: tb/i2c_addr_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_slave_tb_top;
   localparam int QTR  = 20;
   localparam int HALF = 40;
   localparam int NVEC = 8;
   // {ten_bit, own_addr[9:0], first_byte[7:0], expected_ack}
   localparam logic [19:0] ADDR_VEC [NVEC] = '{
      {1'b0, 10'h052, 8'hA4, 1'b1},
      {1'b0, 10'h052, 8'hA6, 1'b0},
      {1'b0, 10'h000, 8'h00, 1'b0},
      {1'b0, 10'h07F, 8'hFE, 1'b1},
      {1'b1, 10'h2A5, 8'hF4, 1'b1},
      {1'b1, 10'h2A5, 8'hF2, 1'b0},
      {1'b1, 10'h2A5, 8'h4A, 1'b0},
      {1'b0, 10'h07A, 8'hF4, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b1;
   logic       ten_bit = 1'b0;
   logic [9:0] own_addr = '0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       host_rd = 1'b0;
   wire        sda_line;
   wire        sda_pull_low;
   wire  [7:0] host_rdata;
   wire        buf_full, overflow, start_flag, stop_flag, start_evt, stop_evt, selected;

   int n_tests = 0;
   int n_fail  = 0;
   int n_start = 0;
   int n_stop  = 0;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull_low;

   i2c_addr_slave dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ten_bit(ten_bit), .own_addr(own_addr),
      .scl_i(scl_m), .sda_i(sda_line), .sda_pull_low(sda_pull_low),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
      .buf_full(buf_full), .overflow(overflow), .start_flag(start_flag), .stop_flag(stop_flag),
      .start_evt(start_evt), .stop_evt(stop_evt), .selected(selected)
   );

   always @(posedge clk) begin
      if (start_evt) n_start <= n_start + 1;
      if (stop_evt)  n_stop  <= n_stop + 1;
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_start();
      sda_m = 1'b1; wt(QTR);
      scl_m = 1'b1; wt(HALF);
      sda_m = 1'b0; wt(HALF);
      scl_m = 1'b0; wt(QTR);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wt(QTR);
      scl_m = 1'b1; wt(HALF);
      sda_m = 1'b1; wt(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wt(QTR);
         scl_m = 1'b1; wt(HALF);
         scl_m = 1'b0; wt(QTR);
      end
      sda_m = 1'b1; wt(QTR);
      scl_m = 1'b1; wt(HALF/2);
      ack = ~sda_line;
      wt(HALF/2);
      scl_m = 1'b0; wt(QTR);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b, output int unstable);
      unstable = 0;
      for (int i = 7; i >= 0; i--) begin
         logic early;
         sda_m = 1'b1; wt(QTR);
         scl_m = 1'b1; wt(HALF/4);
         early = sda_line;
         wt(HALF/2);
         if (sda_line !== early) unstable++;
         b[i] = early;
         wt(HALF/4);
         scl_m = 1'b0; wt(QTR);
      end
      sda_m = ~mack; wt(QTR);
      scl_m = 1'b1; wt(HALF);
      scl_m = 1'b0; wt(QTR);
      sda_m = 1'b1;
   endtask

   task automatic pulse_rd();
      host_rd = 1'b1; wt(1); host_rd = 1'b0; wt(1);
   endtask

   task automatic load_tx(input logic [7:0] d);
      host_wdata = d; host_wr = 1'b1; wt(1); host_wr = 1'b0; wt(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic       ack;
      logic [7:0] rb;
      int         bad;
      int         s0;

      wt(5);
      rst_n = 1'b1;
      wt(5);

      // R1 reset state
      chk("R1 sda_pull_low after reset", sda_pull_low, 0);
      chk("R1 start_flag after reset", start_flag, 0);
      chk("R1 stop_flag after reset", stop_flag, 0);
      chk("R1 buf_full/overflow after reset", {buf_full, overflow}, 0);
      chk("R1 selected after reset", selected, 0);

      // address vector walk: R5 R7 R8 with R3 R4 status
      for (int v = 0; v < NVEC; v++) begin
         ten_bit  = ADDR_VEC[v][19];
         own_addr = ADDR_VEC[v][18:9];
         s0 = n_start;
         do_start();
         chk("R3 start event count", n_start, s0 + 1);
         chk("R3 start_flag/stop_flag", {start_flag, stop_flag}, 2'b10);
         send_byte(ADDR_VEC[v][8:1], ack);
         chk($sformatf("R5 R7 R8 address ack vector %0d", v), ack, ADDR_VEC[v][0]);
         do_stop();
         chk("R4 stop_flag/start_flag", {stop_flag, start_flag}, 2'b10);
         chk("R4 deselected after stop", selected, 0);
      end

      // R10 / R11 write path, 7-bit
      ten_bit = 1'b0; own_addr = 10'h052;
      do_start();
      send_byte(8'hA4, ack);
      chk("R5 ack on 7-bit write", ack, 1);
      chk("R5 selected", selected, 1);
      send_byte(8'hA5, ack);
      chk("R10 data ack", ack, 1);
      chk("R10 host_rdata", host_rdata, 8'hA5);
      chk("R10 buf_full", buf_full, 1);
      send_byte(8'h3C, ack);
      chk("R11 nack when full", ack, 0);
      chk("R11 overflow set", overflow, 1);
      chk("R11 buffer kept", host_rdata, 8'hA5);
      do_stop();
      pulse_rd();
      chk("R11 host_rd clears full/overflow", {buf_full, overflow}, 2'b00);

      // R6 mismatch then data ignored
      do_start();
      send_byte(8'h40, ack);
      chk("R6 mismatch nack", ack, 0);
      send_byte(8'h77, ack);
      chk("R6 data after mismatch nack", ack, 0);
      chk("R6 buffer untouched", {buf_full, host_rdata}, {1'b0, 8'hA5});
      do_stop();

      // R8 / R9 10-bit write then read
      ten_bit = 1'b1; own_addr = 10'h2A5;
      do_start();
      send_byte(8'hF4, ack);
      chk("R8 first byte ack", ack, 1);
      send_byte(8'hA5, ack);
      chk("R8 second byte ack", ack, 1);
      chk("R8 selected", selected, 1);
      send_byte(8'h11, ack);
      chk("R10 10-bit data ack", ack, 1);
      chk("R10 10-bit host_rdata", host_rdata, 8'h11);
      pulse_rd();
      load_tx(8'hC3);
      do_start();
      send_byte(8'hF5, ack);
      chk("R9 read header ack after match", ack, 1);
      recv_byte(1'b1, rb, bad);
      chk("R12 first tx byte", rb, 8'hC3);
      chk("R12 sda stable while scl high", bad, 0);
      recv_byte(1'b0, rb, bad);
      chk("R12 repeat after master ack", rb, 8'hC3);
      chk("R12 sda stable second byte", bad, 0);
      chk("R12 released after master nack", sda_pull_low, 0);
      do_stop();

      do_start();
      send_byte(8'hF4, ack);
      chk("R8 first byte ack again", ack, 1);
      send_byte(8'hA6, ack);
      chk("R8 second byte mismatch nack", ack, 0);
      chk("R8 not selected", selected, 0);
      do_stop();

      do_start();
      send_byte(8'hF5, ack);
      chk("R9 read header without match nack", ack, 0);
      do_stop();

      // R12 7-bit read
      ten_bit = 1'b0; own_addr = 10'h052;
      load_tx(8'h96);
      do_start();
      send_byte(8'hA5, ack);
      chk("R5 read address ack", ack, 1);
      recv_byte(1'b0, rb, bad);
      chk("R12 7-bit tx byte", rb, 8'h96);
      chk("R12 7-bit sda stable", bad, 0);
      do_stop();

      // R2 glitch filter boundary
      wt(10);
      s0 = n_start;
      sda_m = 1'b0; wt(2); sda_m = 1'b1; wt(30);
      chk("R2 two-sample pulse ignored", n_start, s0);
      chk("R2 stop_flag kept", {start_flag, stop_flag}, 2'b01);
      sda_m = 1'b0; wt(3); sda_m = 1'b1; wt(30);
      chk("R2 three-sample pulse accepted", n_start, s0 + 1);

      // R1 disabled block ignores bus
      enable = 1'b0; wt(3);
      s0 = n_start;
      do_start();
      send_byte(8'hA4, ack);
      chk("R1 no ack while disabled", ack, 0);
      chk("R1 no start event while disabled", n_start, s0);
      chk("R1 flags clear while disabled", {start_flag, stop_flag}, 2'b00);
      do_stop();
      chk("R1 stop ignored while disabled", stop_flag, 0);
      enable = 1'b1; wt(10);
      do_start();
      send_byte(8'hA4, ack);
      chk("R1 ack after re-enable", ack, 1);
      do_stop();

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule